// File: doc/BRIEF.md
# 8-bit Execute Unit with Truth Flag

This block is the execute stage of a small 8-bit processor. Each cycle it can take one operation: a 4-bit primary opcode, a 3-bit sub-operation field and two 8-bit operands. The operands are `src_i`, the source register value, and `tgt_i`, the target register value. Arithmetic and bitwise operations are purely combinational. They present an 8-bit result together with a write strobe, and the register file stores the result into the target register at the next clock edge.

The compare operation does not write a general register. It checks one of six unsigned relations between the source and the target and loads the outcome into a single clocked truth bit. Later predicated instructions read that bit. The truth bit has a synchronous, active-high reset that clears it.

Primary opcode values: 6 = compare, 7 = add, 8 = subtract, 9 = bitwise group. Any other value is a no-operation for this unit.

Top module: `alu8_exec`

## Requirements
- R1: When `valid_i`=1 and opcode 7 (add) is applied, `result_o` = (`src_i` + `tgt_i`) mod 256 and `wr_en_o`=1 in the same cycle.
- R2: When `valid_i`=1 and opcode 8 (subtract) is applied, `result_o` = (`src_i` - `tgt_i`) mod 256 and `wr_en_o`=1.
- R3: When `valid_i`=1 and opcode 9 is applied, sub-code 000 gives `src_i` XOR `tgt_i`, 001 gives OR and 010 gives AND, each with `wr_en_o`=1.
- R4: For opcode 9, sub-code 011 shifts `src_i` right by one bit and fills bit 7 with zero. Sub-code 100 shifts `src_i` left by one bit and fills bit 0 with zero. Both set `wr_en_o`=1.
- R5: For opcode 9, sub-code 101 gives the bitwise inverse of `src_i` with `wr_en_o`=1. Sub-codes 110 and 111 give `wr_en_o`=0 and `result_o`=0.
- R6: When `valid_i`=1 and opcode 6 (compare) is applied, the sub-code selects an unsigned relation of `src_i` against `tgt_i`: 000 less than, 001 less or equal, 010 greater than, 011 greater or equal, 100 equal, 101 not equal. The outcome appears on `truth_o` after the next rising clock edge.
- R7: A compare never asserts `wr_en_o`, and drives `result_o`=0.
- R8: A compare with sub-code 110 or 111 leaves `truth_o` unchanged.
- R9: `truth_o` holds its value across every cycle in which no valid compare with sub-code 000 to 101 is applied.
- R10: When `rst`=1 at a rising edge, `truth_o` becomes 0, even if a compare is applied in that cycle.
- R11: When `valid_i`=0, or when the opcode is anything other than 6 to 9, `wr_en_o`=0 and `result_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the truth bit updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the truth bit |
| valid_i | input | 1 | An operation is presented this cycle |
| opcode_i | input | 4 | Primary opcode (6 compare, 7 add, 8 subtract, 9 bitwise) |
| subop_i | input | 3 | Sub-operation: relation code or bitwise function |
| src_i | input | 8 | Source operand |
| tgt_i | input | 8 | Target operand, which is also the second input |
| result_o | output | 8 | Result to write into the target register |
| wr_en_o | output | 1 | The target register takes `result_o` |
| truth_o | output | 1 | Registered truth bit |

## Verification
The only internal state is the truth bit. If it is corrupted, the error shows on `truth_o` one edge after the faulty compare, or one edge after a cycle that should have held the bit. The bench therefore samples `truth_o` after every edge. Interleaving compares with non-compare and reserved codes exposes a bit that drifts when it should hold. The datapath keeps no state, so a wrong result or strobe shows on `result_o` and `wr_en_o` in the same cycle as the stimulus.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int unsigned DW  = 8;
    localparam int unsigned OPW = 4;
    localparam int unsigned SW  = 3;

    typedef enum logic [OPW-1:0] {
        OPC_CMP = 4'd6,
        OPC_ADD = 4'd7,
        OPC_SUB = 4'd8,
        OPC_BIT = 4'd9
    } opc_e;

    typedef enum logic [SW-1:0] {
        BF_XOR  = 3'd0,
        BF_OR   = 3'd1,
        BF_AND  = 3'd2,
        BF_SHR  = 3'd3,
        BF_SHL  = 3'd4,
        BF_INV  = 3'd5,
        BF_RSV6 = 3'd6,
        BF_RSV7 = 3'd7
    } bitfn_e;

    typedef enum logic [SW-1:0] {
        RL_LT   = 3'd0,
        RL_LE   = 3'd1,
        RL_GT   = 3'd2,
        RL_GE   = 3'd3,
        RL_EQ   = 3'd4,
        RL_NE   = 3'd5,
        RL_RSV6 = 3'd6,
        RL_RSV7 = 3'd7
    } rel_e;

    typedef struct packed {
        logic [DW-1:0] val;
        logic          we;
    } unit_out_t;

    // Relation codes 110 and 111 carry no meaning.
    function automatic logic rel_defined(input logic [SW-1:0] code);
        return (code <= 3'd5);
    endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  logic         do_sub,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    logic [W-1:0] b_eff;
    logic [W:0]   full;

    // Subtract as a + ~b + 1, sharing one adder with add.
    always_comb begin
        b_eff = do_sub ? ~b : b;
        full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, do_sub};
        y     = full[W-1:0];
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  logic [SW-1:0] fn,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output unit_out_t     o
);
    always_comb begin
        o.val = '0;
        o.we  = 1'b1;
        unique case (bitfn_e'(fn))
            BF_XOR:  o.val = a ^ b;
            BF_OR:   o.val = a | b;
            BF_AND:  o.val = a & b;
            BF_SHR:  o.val = {1'b0, a[W-1:1]};
            BF_SHL:  o.val = {a[W-2:0], 1'b0};
            BF_INV:  o.val = ~a;
            default: o.we  = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu8_cmp.sv
module alu8_cmp
    import alu8_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [SW-1:0] rel,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic          truth
);
    logic lt, eq, verdict, load;

    always_comb begin
        lt = (a < b);
        eq = (a == b);
        unique case (rel_e'(rel))
            RL_LT:   verdict = lt;
            RL_LE:   verdict = lt | eq;
            RL_GT:   verdict = ~(lt | eq);
            RL_GE:   verdict = ~lt;
            RL_EQ:   verdict = eq;
            RL_NE:   verdict = ~eq;
            default: verdict = 1'b0;
        endcase
        load = en && rel_defined(rel);
    end

    always_ff @(posedge clk) begin
        if (rst)       truth <= 1'b0;
        else if (load) truth <= verdict;
    end

    // R10
    a_r10_reset_clears: assert property (@(posedge clk) rst |=> !truth);
    // R8
    a_r8_reserved_hold: assert property (@(posedge clk) disable iff (rst)
        (en && !rel_defined(rel)) |=> $stable(truth));
    // R9
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(truth));
    // R6
    a_r6_eq_loads: assert property (@(posedge clk) disable iff (rst)
        (en && rel == 3'd4) |=> (truth == ($past(a) == $past(b))));
endmodule

// File: rtl/alu8_exec.sv
module alu8_exec
    import alu8_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       valid_i,
    input  logic [3:0] opcode_i,
    input  logic [2:0] subop_i,
    input  logic [7:0] src_i,
    input  logic [7:0] tgt_i,
    output logic [7:0] result_o,
    output logic       wr_en_o,
    output logic       truth_o
);
    logic          is_cmp, is_add, is_sub, is_bit;
    logic [DW-1:0] arith_y;
    unit_out_t     bit_o;
    unit_out_t     sel;

    always_comb begin
        is_cmp = valid_i && (opcode_i == OPC_CMP);
        is_add = valid_i && (opcode_i == OPC_ADD);
        is_sub = valid_i && (opcode_i == OPC_SUB);
        is_bit = valid_i && (opcode_i == OPC_BIT);
    end

    alu8_arith #(.W(DW)) u_arith (
        .do_sub (is_sub),
        .a      (src_i),
        .b      (tgt_i),
        .y      (arith_y)
    );

    alu8_logic #(.W(DW)) u_logic (
        .fn (subop_i),
        .a  (src_i),
        .b  (tgt_i),
        .o  (bit_o)
    );

    alu8_cmp #(.W(DW)) u_cmp (
        .clk   (clk),
        .rst   (rst),
        .en    (is_cmp),
        .rel   (subop_i),
        .a     (src_i),
        .b     (tgt_i),
        .truth (truth_o)
    );

    always_comb begin
        sel = '0;
        if (is_add || is_sub) begin
            sel.val = arith_y;
            sel.we  = 1'b1;
        end else if (is_bit && bit_o.we) begin
            sel = bit_o;
        end
        result_o = sel.val;
        wr_en_o  = sel.we;
    end

    // R7
    a_r7_cmp_no_write: assert property (@(posedge clk) disable iff (rst)
        is_cmp |-> !wr_en_o);
    // R11
    a_r11_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        !valid_i |-> (!wr_en_o && result_o == 8'h00));
    // R4
    a_r4_shl_zero_fill: assert property (@(posedge clk) disable iff (rst)
        (is_bit && subop_i == 3'd4) |-> (wr_en_o && !result_o[0]));
    // R4
    a_r4_shr_zero_fill: assert property (@(posedge clk) disable iff (rst)
        (is_bit && subop_i == 3'd3) |-> (wr_en_o && !result_o[7]));
endmodule

// File: tb/alu8_exec_tb.sv
module alu8_exec_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       valid_i = 1'b0;
    logic [3:0] opcode_i = '0;
    logic [2:0] subop_i = '0;
    logic [7:0] src_i = '0;
    logic [7:0] tgt_i = '0;
    logic [7:0] result_o;
    logic       wr_en_o;
    logic       truth_o;

    int n_run = 0;
    int n_fail = 0;
    logic exp_truth = 1'b0;

    always #5 clk = ~clk;

    alu8_exec dut_i (.*);

    function automatic logic [8:0] model_comb(input logic v, input logic [3:0] op,
                                              input logic [2:0] s, input logic [7:0] a,
                                              input logic [7:0] b);
        // returns {we, value}
        if (!v) return 9'h000;
        case (op)
            4'd7: return {1'b1, 8'(a + b)};
            4'd8: return {1'b1, 8'(a - b)};
            4'd9: case (s)
                3'd0: return {1'b1, a ^ b};
                3'd1: return {1'b1, a | b};
                3'd2: return {1'b1, a & b};
                3'd3: return {1'b1, a >> 1};
                3'd4: return {1'b1, 8'(a << 1)};
                3'd5: return {1'b1, ~a};
                default: return 9'h000;
            endcase
            default: return 9'h000;
        endcase
    endfunction

    function automatic logic model_rel(input logic [2:0] s, input logic [7:0] a,
                                       input logic [7:0] b, input logic old);
        case (s)
            3'd0: return a < b;
            3'd1: return a <= b;
            3'd2: return a > b;
            3'd3: return a >= b;
            3'd4: return a == b;
            3'd5: return a != b;
            default: return old;
        endcase
    endfunction

    function automatic string tag_of(input logic v, input logic [3:0] op, input logic [2:0] s);
        if (!v || op < 4'd6 || op > 4'd9) return "R11";
        if (op == 4'd6) return "R7";
        if (op == 4'd7) return "R1";
        if (op == 4'd8) return "R2";
        if (s <= 3'd2) return "R3";
        if (s <= 3'd4) return "R4";
        return "R5";
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic v, input logic [3:0] op,
                        input logic [2:0] s, input logic [7:0] a, input logic [7:0] b);
        logic [8:0] e;
        string treq;
        @(negedge clk);
        rst = r; valid_i = v; opcode_i = op; subop_i = s; src_i = a; tgt_i = b;
        #1;
        e = model_comb(v, op, s, a, b);
        check(tag_of(v, op, s), {wr_en_o, result_o}, e);
        if (r) begin
            exp_truth = 1'b0; treq = "R10";
        end else if (v && op == 4'd6) begin
            exp_truth = model_rel(s, a, b, exp_truth);
            treq = (s > 3'd5) ? "R8" : "R6";
        end else treq = "R9";
        @(posedge clk);
        #1;
        check(treq, {8'h00, truth_o}, {8'h00, exp_truth});
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h1234_5678;
        void'($urandom(seed));
        // R10 reset state, with a compare that would set the bit
        step(1, 1, 4'd6, 3'd4, 8'h33, 8'h33);
        check("R10", {8'h00, truth_o}, 9'h000);
        // R1 overflow wrap, R2 underflow wrap
        step(0, 1, 4'd7, 3'd0, 8'hFF, 8'h02);
        step(0, 1, 4'd8, 3'd0, 8'h00, 8'h01);
        // R3 basic logic
        step(0, 1, 4'd9, 3'd0, 8'hF0, 8'h3C);
        step(0, 1, 4'd9, 3'd1, 8'hA0, 8'h05);
        step(0, 1, 4'd9, 3'd2, 8'hCC, 8'hAA);
        // R4 shifts with top/bottom bits set
        step(0, 1, 4'd9, 3'd3, 8'hFF, 8'h00);
        step(0, 1, 4'd9, 3'd4, 8'hFF, 8'h00);
        // R5 inverse and reserved codes
        step(0, 1, 4'd9, 3'd5, 8'h5A, 8'h00);
        step(0, 1, 4'd9, 3'd6, 8'h5A, 8'h11);
        step(0, 1, 4'd9, 3'd7, 8'h5A, 8'h11);
        // R6 relations at equal and adjacent boundaries
        for (int k = 0; k < 6; k++) begin
            step(0, 1, 4'd6, 3'(k), 8'h80, 8'h80);
            step(0, 1, 4'd6, 3'(k), 8'h7F, 8'h80);
            step(0, 1, 4'd6, 3'(k), 8'hFF, 8'h00);
        end
        // R8 reserved relation holds a set bit, then a cleared bit
        step(0, 1, 4'd6, 3'd4, 8'h01, 8'h01);
        step(0, 1, 4'd6, 3'd6, 8'h01, 8'h02);
        step(0, 1, 4'd6, 3'd5, 8'h01, 8'h01);
        step(0, 1, 4'd6, 3'd7, 8'h01, 8'h01);
        // R9 idle and other opcodes hold the bit; R11 outputs quiet
        step(0, 1, 4'd6, 3'd0, 8'h00, 8'h01);
        step(0, 0, 4'd6, 3'd5, 8'h01, 8'h01);
        step(0, 1, 4'd0, 3'd0, 8'h12, 8'h34);
        step(0, 1, 4'd15, 3'd2, 8'h12, 8'h34);
        // R10 reset clears a set bit
        step(1, 1, 4'd6, 3'd5, 8'h01, 8'h02);
        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [3:0] op;
            op = ($urandom % 4 == 0) ? 4'($urandom) : 4'(6 + $urandom % 4);
            step(($urandom % 64) == 0, ($urandom % 8) != 0, op, 3'($urandom),
                 8'($urandom), ($urandom % 4 == 0) ? src_i : 8'($urandom));
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule